// File: doc/BRIEF.md
# Synchronous dual-ratio clock divider

This block derives two slower clocks from one input clock. The first output, `half_o`, runs at half the input rate. The second output, `slow_o`, runs at a quarter or a sixth of the input rate, chosen by `sel6_i`. Both dividers advance on the same enabled rising edge of `clk_i`. Every rising edge of `slow_o` therefore falls on a rising edge of `half_o`. A one-cycle marker, `sync_o`, is high during the input cycle just before such a shared rising edge. Downstream logic can use it to line up its own timing with the divided clocks.

A run/stop input, `en_i`, is captured on the falling edge of `clk_i`. The dividers only take a step on a rising edge whose preceding falling edge captured it high. Stopping and restarting thus happens on whole input cycles, and no output pulse is ever cut short. The active-low reset `rst_ni` clears the block at once. Its release passes through a short synchronizer, so several copies released together leave reset on the same edge and stay in step.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While `rst_ni` is low, `half_o`, `slow_o` and `sync_o` are all low. Reset takes hold without waiting for a clock edge.
- R2: `rst_ni` may rise between rising edges while `en_i` is held high. The first output change then appears at the third rising edge of `clk_i` after that release, where `half_o` and `slow_o` both go high.
- R3: On every rising edge that counts as enabled, `half_o` inverts.
- R4: `sel6_i` = 0 gives a period of four input cycles on `slow_o`: two cycles high, then two low. `sel6_i` = 1 gives a period of six: three high, then three low. Counting is in enabled edges.
- R5: Every rising edge of `slow_o` happens on the same clock edge as a rising edge of `half_o`.
- R6: `sel6_i` is sampled only at the enabled edge where `slow_o` rises. The ratio sampled there holds for that whole output period. A change at any other time waits for the next period.
- R7: A rising edge counts as enabled only when `en_i` was high at the falling edge of `clk_i` just before it. The level of `en_i` at the rising edge itself is not used.
- R8: On a rising edge that is not enabled, all three outputs keep their values. On the next enabled edge, counting picks up from the held state, so no high or low phase is shortened.
- R9: `sync_o` goes high at the enabled edge after which the next enabled edge raises both `half_o` and `slow_o`. It drops at that next enabled edge. It stays low after reset until the first period wraps, so the very first shared rise after reset carries no marker.
- R10: Pulling `rst_ni` low in mid-run clears all outputs at once. After release, the block restarts exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| en_i | input | 1 | Run/stop control, captured on the falling clock edge |
| sel6_i | input | 1 | Ratio select for `slow_o`: 0 = divide by four, 1 = divide by six |
| half_o | output | 1 | Input clock divided by two |
| slow_o | output | 1 | Input clock divided by four or six, 50% duty |
| sync_o | output | 1 | High during the cycle before a shared rising edge of both outputs |

## Verification
The overlap that needs the most care is a change of `sel6_i` that lands on the very edge where `slow_o` starts a new period. The same edge must also honour a run/stop decision and, when one is due, drop `sync_o`. The bench provokes this by flipping `sel6_i` at every offset within the period, and by dropping `en_i` during marker cycles. A behavioural model is stepped only on enabled edges and fixes the ratio at each period start. The outputs are compared against it after every rising edge, so a ratio taken at the wrong edge, or a step taken while stopped, shows up as a mismatch in that same cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // ratio choice for the slow divider
  typedef enum logic {
    RATIO_LOW  = 1'b0,
    RATIO_HIGH = 1'b1
  } ratio_e;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  localparam int LastIdx = STAGES - 1;

  logic [LastIdx:0] chain_q;
  logic [LastIdx:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[LastIdx-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[LastIdx];
endmodule

// File: rtl/clkdiv_en_capture.sv
module clkdiv_en_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_q_o
);
  logic en_q;
  logic en_d;

  assign en_d = en_i;

  // falling-edge capture: steps are only granted while the input clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_q_o = en_q;
endmodule

// File: rtl/clkdiv_div2.sv
module clkdiv_div2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic half_o
);
  logic tog_q;
  logic tog_d;

  always_comb begin
    tog_d = tog_q;
    if (adv_i) tog_d = ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= tog_d;
  end

  assign half_o = tog_q;
endmodule

// File: rtl/clkdiv_div46.sv
module clkdiv_div46
  import clkdiv_pkg::*;
#(
  parameter int RATIO_A = 4,
  parameter int RATIO_B = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic sel_i,
  output logic slow_o,
  output logic wrap_o
);
  localparam int MaxRatio = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
  localparam int CntW     = $clog2(MaxRatio);
  localparam logic [CntW-1:0] LastA = CntW'(RATIO_A - 1);
  localparam logic [CntW-1:0] LastB = CntW'(RATIO_B - 1);
  localparam logic [CntW-1:0] HalfA = CntW'(RATIO_A / 2);
  localparam logic [CntW-1:0] HalfB = CntW'(RATIO_B / 2);

  logic [CntW-1:0] pos_q, pos_d, pos_nx;
  ratio_e          mode_q, mode_d, mode_eff;
  logic            slow_q, slow_d;
  logic [CntW-1:0] last_pos, half_pos;
  logic            at_last;

  // the ratio is taken from the select only at the first state of a period
  assign mode_eff = (pos_q == '0) ? ratio_e'(sel_i) : mode_q;
  assign last_pos = (mode_eff == RATIO_HIGH) ? LastB : LastA;
  assign half_pos = (mode_eff == RATIO_HIGH) ? HalfB : HalfA;
  assign at_last  = (pos_q == last_pos);
  assign pos_nx   = at_last ? '0 : pos_q + CntW'(1);

  always_comb begin
    pos_d  = pos_q;
    mode_d = mode_q;
    slow_d = slow_q;
    if (adv_i) begin
      pos_d  = pos_nx;
      mode_d = mode_eff;
      slow_d = (pos_nx != '0) && (pos_nx <= half_pos);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      mode_q <= RATIO_LOW;
      slow_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      mode_q <= mode_d;
      slow_q <= slow_d;
    end
  end

  assign slow_o = slow_q;
  assign wrap_o = at_last;

  // R4: a high phase never outlasts half of the longest period
  logic [CntW-1:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hi_run_q <= '0;
    else if (adv_i && slow_d)  hi_run_q <= slow_q ? hi_run_q + CntW'(1) : CntW'(1);
    else if (adv_i)            hi_run_q <= '0;
  end

  a_r4_high_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run_q <= HalfB);
endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv #(
  parameter int RATIO_A     = 4,
  parameter int RATIO_B     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sel6_i,
  output logic half_o,
  output logic slow_o,
  output logic sync_o
);
  logic rst_sync_n;
  logic en_q;
  logic half_w, slow_w, wrap_w;
  logic mark_q, mark_d;

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  clkdiv_en_capture u_en_cap (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .en_i  (en_i),
    .en_q_o(en_q)
  );

  clkdiv_div2 u_div2 (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .adv_i (en_q),
    .half_o(half_w)
  );

  clkdiv_div46 #(.RATIO_A(RATIO_A), .RATIO_B(RATIO_B)) u_div46 (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .adv_i (en_q),
    .sel_i (sel6_i),
    .slow_o(slow_w),
    .wrap_o(wrap_w)
  );

  // marker: set on the step into the first state of a period
  always_comb begin
    mark_d = mark_q;
    if (en_q) mark_d = wrap_w & half_w;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) mark_q <= 1'b0;
    else             mark_q <= mark_d;
  end

  assign half_o = half_w;
  assign slow_o = slow_w;
  assign sync_o = mark_q;

  a_r8_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !en_q |=> ($stable(half_o) && $stable(slow_o) && $stable(sync_o)));

  a_r3_half_toggles: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    en_q |=> (half_o != $past(half_o)));

  a_r9_marker_precedes_rise: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (sync_o && en_q) |=> ($rose(half_o) && $rose(slow_o) && !sync_o));

  a_r5_rises_aligned: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(slow_o) |-> $rose(half_o));
endmodule

// File: tb/dual_ratio_clkdiv_bench.sv
module dual_ratio_clkdiv_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic sel = 1'b0;
  logic half, slow, sync;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  dual_ratio_clkdiv u_dual_ratio_clkdiv (
    .clk_i (clk),
    .rst_ni(rst_n),
    .en_i  (en),
    .sel6_i(sel),
    .half_o(half),
    .slow_o(slow),
    .sync_o(sync)
  );

  always #5 clk = ~clk;

  // behavioural reference: counts enabled steps and position in the period
  int m_s1 = 0, m_s2 = 0, m_en = 0, m_cnt = 0, m_pos = 0, m_per = 4;

  always @(negedge rst_n) begin
    m_s1 = 0; m_s2 = 0; m_en = 0; m_cnt = 0; m_pos = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_s2 != 0 && m_en != 0) begin
        if (m_pos == 0) m_per = sel ? 6 : 4;
        m_pos = (m_pos + 1) % m_per;
        m_cnt = m_cnt + 1;
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  always @(negedge clk) m_en = (rst_n && m_s2 != 0) ? int'(en) : 0;

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  logic p_half = 1'b0, p_slow = 1'b0;

  // compare after every rising edge
  always @(posedge clk) begin
    #1;
    check({"R3/", cur_req}, half, 1'(m_cnt % 2), "half_o");
    check({"R4/", cur_req}, slow, (m_pos >= 1 && m_pos <= m_per / 2), "slow_o");
    check({"R9/", cur_req}, sync, (m_pos == 0 && m_cnt > 0), "sync_o");
    if (slow && !p_slow) check("R5", half && !p_half, 1'b1, "half_o rises with slow_o");
    p_half = half;
    p_slow = slow;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic h0, s0, y0;
    // R1: held in reset
    step(3);
    check("R1", half | slow | sync, 1'b0, "outputs in reset");

    // R2: release with enable high, first change at third edge
    cur_req = "R2";
    rst_n = 1'b1;
    en = 1'b1;
    step(2);
    check("R2", half | slow, 1'b0, "still low after two edges");
    step(1);
    check("R2", half & slow, 1'b1, "both high at third edge");

    // R4: divide by four
    cur_req = "R4";
    step(30);

    // R6: select change at an arbitrary point, then at every offset
    cur_req = "R6";
    sel = 1'b1;
    step(40);
    for (int i = 0; i < 60; i++) begin
      if (i % 5 == 0 || i % 7 == 3) sel = ~sel;
      step(1);
    end

    // R8: stop and resume, including stops on marker cycles
    cur_req = "R8";
    for (int i = 0; i < 12; i++) begin
      en = 1'b0;
      h0 = half; s0 = slow; y0 = sync;
      step(2 + i % 3);
      check("R8", (half == h0) && (slow == s0) && (sync == y0), 1'b1, "held while stopped");
      en = 1'b1;
      step(1 + i % 4);
    end
    for (int i = 0; i < 30; i++) begin
      en = !sync;
      step(1);
    end
    en = 1'b1;

    // R7: short enable pulses around the falling edge
    cur_req = "R7";
    en = 1'b0;
    step(2);
    h0 = half;
    #4;             // 1 ns after falling edge: not captured by it
    en = 1'b1;
    @(posedge clk);
    #2;
    en = 1'b0;
    step(1);
    check("R7", half, h0, "pulse missing falling edge ignored");
    en = 1'b1;      // present across the falling edge only
    #5;
    en = 1'b0;
    step(1);
    check("R7", half, ~h0, "pulse across falling edge counted");
    en = 1'b1;
    step(10);

    // R10: asynchronous reset mid-run
    cur_req = "R10";
    sel = 1'b0;
    step(5);
    rst_n = 1'b0;
    #1;
    check("R10", half | slow | sync, 1'b0, "cleared without edge");
    step(2);
    rst_n = 1'b1;
    step(2);
    check("R10", half | slow, 1'b0, "low two edges after release");
    step(1);
    check("R10", half & slow, 1'b1, "restart at third edge");

    // mixed stimulus
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      en = ($urandom % 4) != 0;
      if ($urandom % 6 == 0) sel = ~sel;
      step(1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule